// File: doc/BRIEF.md
# Power-Management Bus Command Channel

This block is one command channel of a serial power-management bus master. Software sees a small register window. It first loads up to two 32-bit write-data words. It then writes a command word that packs an opcode, a 4-bit target slave, a 16-bit register address and a byte count. That write starts the transaction. The channel classifies the opcode and drives a request toward the bus side. The request carries the decoded fields and a snapshot of the write data, with unused bytes forced to zero. The request stays up until the bus side returns a one-cycle response with a result code and up to 8 read bytes.

When the response arrives, the channel stores a status word with separate done, failure, denied and dropped bits. A successful read stores the returned bytes in two little-endian read-data words. Software polls the status word until done is set, and only then reads the error bits and the read data. The serial signalling itself lives on the far side of the request/response pair.

Top module: `pwr_cmd_channel`

## Requirements
- R1: After reset, the status word, all data words and the command word read as zero and `req_valid` is low.
- R2: The channel answers only to addresses whose bits above bit 6 equal `CHAN_ID`, so each channel owns a 0x80 window. Inside the window the offsets are: 0x00 command, 0x04 config (reads zero), 0x08 status, 0x10 and 0x14 write data (bytes 0–3 and 4–7), 0x18 and 0x1C read data. A write outside the window changes nothing, and a read outside it returns zero.
- R3: The request fields come from the command word: opcode from bits [31:27], slave from [23:20], register address from [19:4], byte count minus one from [2:0].
- R4: A command write to an idle channel with a supported opcode clears the status word at that clock edge. `req_valid` is high from the next cycle and stays high until the response cycle.
- R5: The status word changes at the clock edge that samples `resp_valid`. Bit 0 is done, bit 1 failure, bit 2 denied and bit 3 dropped. Response code 0 gives 0x1, codes 1 and 3 give 0x3, and code 2 gives 0x5. `req_valid` is low after that edge.
- R6: Write-class opcodes (0, 2, 7, 9, 14, 16) and read-class opcodes raise `req_has_data`. `req_wdata` carries the write words as captured at the command write, byte k in bits [8k+7:8k], and bytes above the count are zero.
- R7: A read-class opcode (1, 8, 13, 15) that completes with code 0 loads the read-data words from `resp_rdata`. Bytes above the count are stored as zero.
- R8: Non-data opcodes 3 to 6 drive `req_has_data` low and leave both read-data words unchanged.
- R9: A response with code 1, 2 or 3 leaves both read-data words unchanged.
- R10: A command write while a transaction is in flight is ignored: the command word and the request do not change. The completing status gains the dropped bit, for example 0x9 for code 0. The next transaction starts with dropped clear.
- R11: Unsupported opcodes (10–12 and 17–31) raise no request. The status word reads 0x3 right after the command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| req_valid | output | 1 | Transaction request pending toward the bus side |
| req_op | output | 5 | Opcode of the pending request |
| req_slave | output | 4 | Target slave ID |
| req_addr | output | 16 | Target register address |
| req_cnt | output | CNT_W | Byte count minus one |
| req_has_data | output | 1 | Request has a data phase |
| req_wdata | output | 8*MAX_BYTES | Write bytes, little-endian, unused bytes zero |
| resp_valid | input | 1 | One-cycle response strobe |
| resp_code | input | 2 | 0 ok, 1 failure, 2 denied, 3 failure |
| resp_rdata | input | 8*MAX_BYTES | Returned read bytes, little-endian |

## Verification
The assertions assume that `resp_valid` is a single-cycle pulse that comes only while `req_valid` is high. They also assume that `resp_code` and `resp_rdata` are valid in that cycle. The bench's bus-side stub drives a response only after it has seen `req_valid` high, and drops `resp_valid` at the next falling edge. It never answers an idle channel. Register accesses are applied one per cycle at the falling edge, and the dropped-command case deliberately writes the command word while a request is outstanding.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;
   // channel-relative register offsets
   localparam logic [6:0] OFF_CMD = 7'h00;
   localparam logic [6:0] OFF_CFG = 7'h04;
   localparam logic [6:0] OFF_STS = 7'h08;
   localparam logic [6:0] OFF_WD0 = 7'h10;
   localparam logic [6:0] OFF_RD0 = 7'h18;

   // status bit positions
   localparam int ST_DONE = 0;
   localparam int ST_FAIL = 1;
   localparam int ST_DENY = 2;
   localparam int ST_DROP = 3;

   // response codes
   localparam logic [1:0] RESP_OK   = 2'd0;
   localparam logic [1:0] RESP_DENY = 2'd2;

   typedef enum logic [1:0] {
      OPC_INVALID,
      OPC_NODATA,
      OPC_WRITE,
      OPC_READ
   } op_class_e;
endpackage

// File: rtl/pcc_op_decode.sv
`timescale 1ns/1ps
module pcc_op_decode
   import pcc_pkg::*;
(
   input  logic [4:0] op,
   output op_class_e  cls
);
   always_comb begin
      unique case (op)
         5'd0, 5'd2, 5'd7, 5'd9, 5'd14, 5'd16: cls = OPC_WRITE;
         5'd1, 5'd8, 5'd13, 5'd15:             cls = OPC_READ;
         5'd3, 5'd4, 5'd5, 5'd6:               cls = OPC_NODATA;
         default:                              cls = OPC_INVALID;
      endcase
   end
endmodule

// File: rtl/pcc_byte_keep.sv
`timescale 1ns/1ps
module pcc_byte_keep #(
   parameter int NBYTES = 8,
   localparam int CNT_W = $clog2(NBYTES)
) (
   input  logic [CNT_W-1:0]    cnt,
   input  logic [8*NBYTES-1:0] din,
   output logic [8*NBYTES-1:0] dout
);
   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      assign dout[8*i +: 8] = ((CNT_W+1)'(i) <= {1'b0, cnt}) ? din[8*i +: 8] : 8'h00;
   end
endmodule

// File: rtl/pwr_cmd_channel.sv
`timescale 1ns/1ps
module pwr_cmd_channel
   import pcc_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int CHAN_ID   = 0,
   parameter int MAX_BYTES = 8,
   localparam int CNT_W     = $clog2(MAX_BYTES),
   localparam int NUM_WORDS = MAX_BYTES / 4,
   localparam int DW        = 8 * MAX_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              req_valid,
   output logic [4:0]        req_op,
   output logic [3:0]        req_slave,
   output logic [15:0]       req_addr,
   output logic [CNT_W-1:0]  req_cnt,
   output logic              req_has_data,
   output logic [DW-1:0]     req_wdata,
   input  logic              resp_valid,
   input  logic [1:0]        resp_code,
   input  logic [DW-1:0]     resp_rdata
);
   if (MAX_BYTES != 4 && MAX_BYTES != 8) begin : g_bad_bytes
      $error("MAX_BYTES must be 4 or 8");
   end
   if (ADDR_W < 8) begin : g_bad_aw
      $error("ADDR_W must be at least 8");
   end
   if (CHAN_ID < 0 || CHAN_ID >= (1 << (ADDR_W - 7))) begin : g_bad_chan
      $error("CHAN_ID does not fit in the address");
   end

   logic [31:0]   cmd_q;
   logic [3:0]    status_q;
   logic          busy_q, drop_q;
   logic [DW-1:0] wdata_q, rdata_q, snap_q;
   logic [DW-1:0] new_snap, rd_kept;
   logic [63:0]   wd_pad, rd_pad;
   op_class_e     new_cls, cur_cls;

   logic       hit, wr, cmd_wr;
   logic [6:0] off;
   assign hit    = (reg_addr[ADDR_W-1:7] == (ADDR_W-7)'(CHAN_ID));
   assign off    = reg_addr[6:0];
   assign wr     = reg_we && hit;
   assign cmd_wr = wr && (off == OFF_CMD);

   pcc_op_decode u_dec_new (.op(reg_wdata[31:27]), .cls(new_cls));
   pcc_op_decode u_dec_cur (.op(cmd_q[31:27]),     .cls(cur_cls));

   pcc_byte_keep #(.NBYTES(MAX_BYTES)) u_keep_wr (
      .cnt(reg_wdata[CNT_W-1:0]), .din(wdata_q), .dout(new_snap));
   pcc_byte_keep #(.NBYTES(MAX_BYTES)) u_keep_rd (
      .cnt(cmd_q[CNT_W-1:0]), .din(resp_rdata), .dout(rd_kept));

   // write-data words, one per 4 bytes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdata_q <= '0;
      end else if (wr) begin
         for (int w = 0; w < NUM_WORDS; w++) begin
            if (off == OFF_WD0 + 7'(4 * w)) wdata_q[32*w +: 32] <= reg_wdata;
         end
      end
   end

   // transaction control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         status_q <= '0;
         busy_q   <= 1'b0;
         drop_q   <= 1'b0;
         snap_q   <= '0;
         rdata_q  <= '0;
      end else if (busy_q) begin
         if (cmd_wr) drop_q <= 1'b1;
         if (resp_valid) begin
            busy_q             <= 1'b0;
            drop_q             <= 1'b0;
            status_q[ST_DONE]  <= 1'b1;
            status_q[ST_FAIL]  <= resp_code[0];
            status_q[ST_DENY]  <= (resp_code == RESP_DENY);
            status_q[ST_DROP]  <= drop_q | cmd_wr;
            if (resp_code == RESP_OK && cur_cls == OPC_READ) rdata_q <= rd_kept;
         end
      end else if (cmd_wr) begin
         cmd_q <= reg_wdata;
         if (new_cls == OPC_INVALID) begin
            status_q <= 4'b0011;
         end else begin
            status_q <= '0;
            busy_q   <= 1'b1;
            snap_q   <= new_snap;
         end
      end
   end

   assign req_valid    = busy_q;
   assign req_op       = cmd_q[31:27];
   assign req_slave    = cmd_q[23:20];
   assign req_addr     = cmd_q[19:4];
   assign req_cnt      = cmd_q[CNT_W-1:0];
   assign req_has_data = (cur_cls == OPC_WRITE) || (cur_cls == OPC_READ);
   assign req_wdata    = snap_q;

   assign wd_pad = 64'(wdata_q);
   assign rd_pad = 64'(rdata_q);

   always_comb begin
      reg_rdata = '0;
      if (hit) begin
         case (off)
            OFF_CMD:         reg_rdata = cmd_q;
            OFF_CFG:         reg_rdata = '0;
            OFF_STS:         reg_rdata = {28'd0, status_q};
            OFF_WD0:         reg_rdata = wd_pad[31:0];
            OFF_WD0 + 7'd4:  reg_rdata = wd_pad[63:32];
            OFF_RD0:         reg_rdata = rd_pad[31:0];
            OFF_RD0 + 7'd4:  reg_rdata = rd_pad[63:32];
            default:         reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/pcc_chk.sv
`timescale 1ns/1ps
module pcc_chk
   import pcc_pkg::*;
#(
   parameter int W = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic [3:0]    status,
   input logic          resp_valid,
   input logic [1:0]    resp_code,
   input logic          cmd_wr,
   input logic          launch_ok,
   input logic          cur_nodata,
   input logic [W-1:0]  rdata,
   input logic [31:0]   cmd
);
   // R4
   launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_wr && launch_ok) |=> (busy && status == 4'd0));

   // R5
   done_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && resp_valid) |=> (status[ST_DONE] && !busy));

   // R5
   done_means_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_DONE] |-> !busy);

   // R8
   nodata_keeps_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && resp_valid && cur_nodata) |=> $stable(rdata));

   // R9
   deny_keeps_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && resp_valid && resp_code == RESP_DENY) |=>
         (status[ST_DENY] && status[ST_DONE] && $stable(rdata)));

   // R10
   busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr) |=> $stable(cmd));
endmodule

bind pwr_cmd_channel pcc_chk #(.W(8 * MAX_BYTES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy_q),
   .status     (status_q),
   .resp_valid (resp_valid),
   .resp_code  (resp_code),
   .cmd_wr     (cmd_wr),
   .launch_ok  (new_cls != pcc_pkg::OPC_INVALID),
   .cur_nodata (cur_cls == pcc_pkg::OPC_NODATA),
   .rdata      (rdata_q),
   .cmd        (cmd_q)
);

// File: tb/tb_pwr_cmd_channel.sv
`timescale 1ns/1ps
module tb_pwr_cmd_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        req_valid, req_has_data;
   logic [4:0]  req_op;
   logic [3:0]  req_slave;
   logic [15:0] req_addr;
   logic [2:0]  req_cnt;
   logic [63:0] req_wdata;
   logic        resp_valid = 1'b0;
   logic [1:0]  resp_code = '0;
   logic [63:0] resp_rdata = '0;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   pwr_cmd_channel dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
      .req_op(req_op), .req_slave(req_slave), .req_addr(req_addr),
      .req_cnt(req_cnt), .req_has_data(req_has_data), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_code(resp_code), .resp_rdata(resp_rdata));

   typedef struct packed {
      logic [4:0]  op;
      logic [3:0]  sl;
      logic [15:0] ad;
      logic [2:0]  cnt;
      logic [1:0]  code;
      logic [63:0] wd;
      logic [63:0] rd;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{5'd15, 4'h3, 16'h1234, 3'd7, 2'd0, 64'h0,                   64'h8877_6655_4433_2211},
      '{5'd1,  4'hA, 16'hBEEF, 3'd2, 2'd0, 64'h0,                   64'hFFFF_FFFF_FFAA_BBCC},
      '{5'd14, 4'h5, 16'h0042, 3'd5, 2'd0, 64'h1122_3344_5566_7788, 64'h0},
      '{5'd13, 4'h1, 16'h00F0, 3'd3, 2'd2, 64'h0,                   64'hDEAD_BEEF_CAFE_F00D},
      '{5'd4,  4'h2, 16'h0000, 3'd7, 2'd0, 64'h0,                   64'h0123_4567_89AB_CDEF},
      '{5'd8,  4'h7, 16'h0101, 3'd0, 2'd1, 64'h0,                   64'h5555_5555_5555_5555},
      '{5'd16, 4'hF, 16'hFFFF, 3'd0, 2'd0, 64'hCDCD_CDCD_CDCD_CDAB, 64'h0},
      '{5'd1,  4'h0, 16'h8000, 3'd4, 2'd3, 64'h0,                   64'h7777_7777_7777_7777}
   };

   function automatic logic [63:0] keep(input logic [63:0] d, input logic [2:0] c);
      logic [63:0] r = '0;
      for (int b = 0; b < 8; b++) if (b <= int'(c)) r[8*b +: 8] = d[8*b +: 8];
      return r;
   endfunction

   function automatic logic [31:0] mkcmd(input logic [4:0] op, input logic [3:0] sl,
                                         input logic [15:0] ad, input logic [2:0] c);
      return {op, 3'b000, sl, ad, 1'b0, c};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic respond(input logic [1:0] c, input logic [63:0] d);
      resp_valid = 1'b1; resp_code = c; resp_rdata = d;
      @(negedge clk);
      resp_valid = 1'b0;
   endtask

   logic [63:0] exp_rd = '0;
   logic [31:0] v, v2;

   initial begin
      #(20 * 100000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 req_valid", 64'(req_valid), 64'd0);
      rd(12'h008, v); chk("R1 status", 64'(v), 64'd0);
      rd(12'h018, v); rd(12'h01C, v2); chk("R1 rdata", {v2, v}, 64'd0);
      rd(12'h000, v); chk("R1 cmd", 64'(v), 64'd0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         vec_t t = VEC[i];
         logic [3:0] exp_st;
         logic is_read, is_nodata;
         is_read   = (t.op == 5'd1 || t.op == 5'd8 || t.op == 5'd13 || t.op == 5'd15);
         is_nodata = (t.op >= 5'd3 && t.op <= 5'd6);
         wr(12'h010, t.wd[31:0]);
         wr(12'h014, t.wd[63:32]);
         wr(12'h000, mkcmd(t.op, t.sl, t.ad, t.cnt));
         chk("R4 req_valid raised", 64'(req_valid), 64'd1);
         rd(12'h008, v); chk("R4 status cleared", 64'(v), 64'd0);
         chk("R3 fields", {27'd0, req_op, req_slave, req_addr, req_cnt},
             {27'd0, t.op, t.sl, t.ad, t.cnt});
         if (is_nodata) chk("R8 no data phase", 64'(req_has_data), 64'd0);
         else begin
            chk("R6 data phase", 64'(req_has_data), 64'd1);
            chk("R6 req_wdata", req_wdata, keep(t.wd, t.cnt));
         end
         respond(t.code, t.rd);
         exp_st = (t.code == 2'd0) ? 4'h1 : (t.code == 2'd2) ? 4'h5 : 4'h3;
         rd(12'h008, v); chk("R5 status", 64'(v), 64'(exp_st));
         chk("R5 req_valid low", 64'(req_valid), 64'd0);
         if (is_read && t.code == 2'd0) exp_rd = keep(t.rd, t.cnt);
         rd(12'h018, v); rd(12'h01C, v2);
         if (is_nodata)            chk("R8 rdata kept", {v2, v}, exp_rd);
         else if (t.code != 2'd0)  chk("R9 rdata kept", {v2, v}, exp_rd);
         else                      chk("R7 rdata", {v2, v}, exp_rd);
      end

      // R2 window: channel 1 address does not touch channel 0
      wr(12'h010, 32'hA5A5_0001);
      wr(12'h090, 32'hFFFF_FFFF);
      rd(12'h010, v); chk("R2 outside write ignored", 64'(v), 64'hA5A5_0001);
      rd(12'h090, v); chk("R2 outside read zero", 64'(v), 64'd0);
      wr(12'h004, 32'h1234_5678);
      rd(12'h004, v); chk("R2 config reads zero", 64'(v), 64'd0);

      // R4 request held while no response
      wr(12'h000, mkcmd(5'd15, 4'h9, 16'h4444, 3'd1));
      repeat (3) @(negedge clk);
      chk("R4 request held", 64'(req_valid), 64'd1);
      // R10 command while busy
      wr(12'h000, mkcmd(5'd14, 4'h1, 16'h1111, 3'd0));
      rd(12'h000, v); chk("R10 cmd unchanged", 64'(v), 64'(mkcmd(5'd15, 4'h9, 16'h4444, 3'd1)));
      chk("R10 request unchanged", {48'd0, req_addr}, 64'h4444);
      respond(2'd0, 64'h0000_0000_0000_BEAD);
      rd(12'h008, v); chk("R10 dropped status", 64'(v), 64'h9);
      rd(12'h018, v); chk("R7 read after drop", 64'(v), 64'h0000_BEAD);
      wr(12'h000, mkcmd(5'd6, 4'h2, 16'h0, 3'd0));
      respond(2'd0, 64'h0);
      rd(12'h008, v); chk("R10 dropped cleared next", 64'(v), 64'h1);

      // R11 unsupported opcodes
      wr(12'h000, mkcmd(5'd10, 4'h1, 16'h2, 3'd0));
      rd(12'h008, v); chk("R11 status op10", 64'(v), 64'h3);
      chk("R11 no request op10", 64'(req_valid), 64'd0);
      wr(12'h000, mkcmd(5'd31, 4'h1, 16'h2, 3'd0));
      @(negedge clk);
      chk("R11 no request op31", 64'(req_valid), 64'd0);
      rd(12'h008, v); chk("R11 status op31", 64'(v), 64'h3);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule